// File: doc/BRIEF.md
# Clock Generator Control and Status Register Block

This block is the register front end of a multi-mode clock generator. Software writes three control registers over a simple synchronous write bus and reads them back, together with a read-only status register, through a combinational read port. The three control registers cover clock-source selection with the reference divider, crystal oscillator setup, and the FLL multiplier range.

The status flags do not copy the control bits. Each one comes from a small cycle-counting model of the hardware it reports on: oscillator start-up, the switch of the FLL reference between the internal and external sources, the switch of the output clock source, and FLL lock. Each flag therefore follows a control write only after a programmable delay, and only once its preconditions hold. Lock is lost whenever the FLL reference or the multiplier range changes, and it is then regained after a fixed acquisition time. The FLL stays enabled, and reports lock, even while it is not the selected clock source.

The block also drives the effective FLL multiplication factor and the effective reference divide, given as a power of two, so that neighbouring logic can use them. The analog parts, the DCO and glitch-free clock muxing lie outside this block.

Top module: `clkgen_ctrl_regs`

## Requirements
- R1: After reset the clock register (address 0) reads 0x02, the oscillator register (address 1) reads 0x00, the range register (address 2) reads 0x00, and the status register (address 3) reads 0x10.
- R2: Only defined fields are stored. In the clock register these are source select [7:6], divider code [5:3] and internal-reference select [1]. In the oscillator register they are high-frequency range [5], high gain [4], crystal select [2] and external-reference enable [1]. In the range register the range code is [1:0]. All other bits read 0, and read data follows the address in the same cycle.
- R3: Status bit 1 (oscillator ready) sets OSC_START_CYC clock edges after the write edge that makes oscillator bits 2 and 1 both 1. It clears on the edge after either of those bits is cleared.
- R4: Status bit 4 (internal reference in use) clears REF_SW_CYC+1 edges after internal-reference select is 0 and the oscillator is ready. It sets again REF_SW_CYC+1 edges after either condition stops holding.
- R5: Status bit 6 (lock) clears on the second edge after a write that changes the range code, or on the edge after status bit 4 changes. It sets again LOCK_CYC edges after that clearing edge. A write that leaves the range code unchanged keeps lock.
- R6: Status bits [3:2] (source in use; 00 FLL, 01 internal, 10 external) take the value of the source select CLK_SW_CYC+1 edges after the write. Code 10 waits for the oscillator to be ready, and code 11 is never adopted.
- R7: The multiplier output equals 512 × (range code + 1): 512 for 00, 1024 for 01, 1536 for 10 and 2048 for 11.
- R8: The divide output equals the divider code plus 5 when the high-frequency range bit is set, and the divider code alone otherwise. Code 011 in the high range therefore gives 8, a divide by 256.
- R9: Writes to the status address change no register.
- R10: A write to one address leaves the other control registers unchanged.
- R11: Lock is reported whatever clock source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| fll_mult_o | output | 12 | Effective FLL multiplication factor |
| ref_div_log2_o | output | 4 | Effective reference divide as a power of two |

## Verification
The properties assume that the write strobe is a clean one-cycle pulse with a stable address and data, and that the range register changes only through the bus. They also assume that status bit 4 can fall only when the oscillator was ready in the cycle before. The stimulus issues writes only on falling clock edges, with each strobe held for exactly one cycle. After each write it waits long enough for every handshake to settle before checking a flag, except where a check is timed on purpose to land one cycle before or after an expected transition. The stimulus also exercises the reserved source code and clears the oscillator enable while the external reference is in use, so the properties cover both the refusal paths and the fall-back path.

// File: rtl/clkgen_regs_pkg.sv
package clkgen_regs_pkg;

    localparam int DATA_W        = 8;
    localparam int MULT_W        = 12;
    localparam int FLL_BASE_MULT = 512;
    localparam int HF_EXTRA_DIV  = 5;

    typedef enum logic [1:0] {
        ADDR_CLKCTL = 2'd0,
        ADDR_OSCCTL = 2'd1,
        ADDR_FLLRNG = 2'd2,
        ADDR_STATUS = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_FLL  = 2'd0,
        SRC_INT  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_RSVD = 2'd3
    } clk_src_e;

    typedef struct packed {
        clk_src_e   src;
        logic [2:0] ref_div;
        logic       rsv2;
        logic       int_ref;
        logic       rsv0;
    } clkctl_t;

    typedef struct packed {
        logic [1:0] rsv76;
        logic       hf_range;
        logic       high_gain;
        logic       rsv3;
        logic       xtal_sel;
        logic       ext_en;
        logic       rsv0;
    } oscctl_t;

    typedef struct packed {
        logic     rsv7;
        logic     locked;
        logic     rsv5;
        logic     int_ref_act;
        clk_src_e src_act;
        logic     osc_ready;
        logic     rsv0;
    } status_t;

    localparam logic [DATA_W-1:0] CLKCTL_RST  = 8'h02;
    localparam logic [DATA_W-1:0] CLKCTL_MASK = 8'hFA;
    localparam logic [DATA_W-1:0] OSCCTL_RST  = 8'h00;
    localparam logic [DATA_W-1:0] OSCCTL_MASK = 8'h36;
    localparam logic [DATA_W-1:0] FLLRNG_RST  = 8'h00;
    localparam logic [DATA_W-1:0] FLLRNG_MASK = 8'h03;

    function automatic logic [MULT_W-1:0] fll_factor(input logic [1:0] rng);
        fll_factor = MULT_W'(FLL_BASE_MULT) * (MULT_W'(rng) + MULT_W'(1));
    endfunction

    function automatic logic [3:0] div_log2(input logic [2:0] code, input logic hf);
        div_log2 = {1'b0, code} + (hf ? 4'(HF_EXTRA_DIV) : 4'd0);
    endfunction

endpackage

// File: rtl/clkgen_handshake_delay.sv
module clkgen_handshake_delay #(
    parameter int             W       = 1,
    parameter int             DLY     = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tgt_i,
    output logic [W-1:0] cur_o
);
    localparam int CNT_W = $clog2(DLY + 1);

    logic [W-1:0]     pend_q;
    logic [CNT_W-1:0] cnt_q;

    // A new target restarts the wait; the reported value moves only after DLY steady cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_o  <= RST_VAL;
            pend_q <= RST_VAL;
            cnt_q  <= '0;
        end else if (tgt_i != pend_q) begin
            pend_q <= tgt_i;
            cnt_q  <= '0;
        end else if (cur_o != pend_q) begin
            if (cnt_q == CNT_W'(DLY - 1)) begin
                cur_o <= pend_q;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/clkgen_osc_model.sv
module clkgen_osc_model #(
    parameter int START_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(START_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q   <= '0;
            ready_o <= 1'b0;
        end else if (!ready_o) begin
            if (cnt_q == CNT_W'(START_CYC - 1)) begin
                ready_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/clkgen_lock_model.sv
module clkgen_lock_model #(
    parameter int LOCK_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_int_i,
    input  logic [1:0] rng_i,
    output logic       locked_o
);
    localparam int CNT_W = $clog2(LOCK_CYC + 1);

    logic             ref_q;
    logic [1:0]       rng_q;
    logic [CNT_W-1:0] cnt_q;
    logic             disturb;

    assign disturb = (ref_int_i != ref_q) || (rng_i != rng_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q    <= 1'b1;
            rng_q    <= 2'b00;
            cnt_q    <= '0;
            locked_o <= 1'b0;
        end else begin
            ref_q <= ref_int_i;
            rng_q <= rng_i;
            if (disturb) begin
                locked_o <= 1'b0;
                cnt_q    <= '0;
            end else if (!locked_o) begin
                if (cnt_q == CNT_W'(LOCK_CYC - 1)) begin
                    locked_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/clkgen_ctrl_regs.sv
module clkgen_ctrl_regs
    import clkgen_regs_pkg::*;
#(
    parameter int OSC_START_CYC = 20,
    parameter int REF_SW_CYC    = 4,
    parameter int CLK_SW_CYC    = 3,
    parameter int LOCK_CYC      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [MULT_W-1:0] fll_mult_o,
    output logic [3:0]        ref_div_log2_o
);
    clkctl_t          clk_q;
    oscctl_t          osc_q;
    logic [DATA_W-1:0] rng_q;
    status_t          stat;

    logic       osc_en;
    logic       osc_ready;
    logic       ref_tgt;
    logic       int_ref_act;
    logic [1:0] src_tgt;
    logic [1:0] src_act_raw;
    logic       locked;

    // R2, R9, R10: each address owns one register; status address stores nothing.
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q <= clkctl_t'(CLKCTL_RST);
            osc_q <= oscctl_t'(OSCCTL_RST);
            rng_q <= FLLRNG_RST;
        end else if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                ADDR_CLKCTL: clk_q <= clkctl_t'(bus_wdata & CLKCTL_MASK);
                ADDR_OSCCTL: osc_q <= oscctl_t'(bus_wdata & OSCCTL_MASK);
                ADDR_FLLRNG: rng_q <= bus_wdata & FLLRNG_MASK;
                default: ;
            endcase
        end
    end

    assign osc_en = osc_q.xtal_sel & osc_q.ext_en;

    clkgen_osc_model #(.START_CYC(OSC_START_CYC)) osc_i (
        .clk(clk), .rst(rst), .en_i(osc_en), .ready_o(osc_ready)
    );

    // External reference is only taken once the oscillator is up.
    assign ref_tgt = clk_q.int_ref | ~osc_ready;

    clkgen_handshake_delay #(.W(1), .DLY(REF_SW_CYC), .RST_VAL(1'b1)) ref_sw_i (
        .clk(clk), .rst(rst), .tgt_i(ref_tgt), .cur_o(int_ref_act)
    );

    always_comb begin
        src_tgt = clk_q.src;
        if (clk_q.src == SRC_RSVD || (clk_q.src == SRC_EXT && !osc_ready)) begin
            src_tgt = src_act_raw;
        end
    end

    clkgen_handshake_delay #(.W(2), .DLY(CLK_SW_CYC), .RST_VAL(2'b00)) src_sw_i (
        .clk(clk), .rst(rst), .tgt_i(src_tgt), .cur_o(src_act_raw)
    );

    clkgen_lock_model #(.LOCK_CYC(LOCK_CYC)) lock_i (
        .clk(clk), .rst(rst), .ref_int_i(int_ref_act), .rng_i(rng_q[1:0]), .locked_o(locked)
    );

    always_comb begin
        stat             = '0;
        stat.locked      = locked;
        stat.int_ref_act = int_ref_act;
        stat.src_act     = clk_src_e'(src_act_raw);
        stat.osc_ready   = osc_ready;
    end

    always_comb begin
        case (reg_addr_e'(bus_addr))
            ADDR_CLKCTL: bus_rdata = clk_q;
            ADDR_OSCCTL: bus_rdata = osc_q;
            ADDR_FLLRNG: bus_rdata = rng_q;
            default:     bus_rdata = stat;
        endcase
    end

    assign fll_mult_o     = fll_factor(rng_q[1:0]);
    assign ref_div_log2_o = div_log2(clk_q.ref_div, osc_q.hf_range);

endmodule

// File: rtl/clkgen_ctrl_regs_chk.sv
module clkgen_ctrl_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] clk_reg,
    input logic [7:0] osc_reg,
    input logic [7:0] rng_reg,
    input logic [7:0] status
);
    a_r5_range_change_drops_lock: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2 && bus_wdata[1:0] != rng_reg[1:0]) |=> ##1 !status[6]);

    a_r3_osc_off_clears_ready: assert property (@(posedge clk) disable iff (rst)
        !(osc_reg[2] && osc_reg[1]) |=> !status[1]);

    a_r4_ext_ref_needs_osc: assert property (@(posedge clk) disable iff (rst)
        $fell(status[4]) |-> $past(status[1]));

    a_r6_src_follows_select: assert property (@(posedge clk) disable iff (rst)
        !$stable(status[3:2]) |-> (status[3:2] == $past(clk_reg[7:6])));

    a_r6_rsvd_never_active: assert property (@(posedge clk) disable iff (rst)
        status[3:2] != 2'b11);

    a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3) |=> ($stable(clk_reg) && $stable(osc_reg) && $stable(rng_reg)));

    a_r10_clkctl_isolated: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != 2'd0) |=> $stable(clk_reg));
endmodule

bind clkgen_ctrl_regs clkgen_ctrl_regs_chk chk_i (
    .clk(clk),
    .rst(rst),
    .bus_wr(bus_wr),
    .bus_addr(bus_addr),
    .bus_wdata(bus_wdata),
    .clk_reg(clk_q),
    .osc_reg(osc_q),
    .rng_reg(rng_q),
    .status(stat)
);

// File: tb/clkgen_ctrl_regs_tb_top.sv
`timescale 1ns/10ps
module clkgen_ctrl_regs_tb_top;
    localparam int OSC_CYC  = 20;
    localparam int REF_CYC  = 4;
    localparam int CLK_CYC  = 3;
    localparam int LOCK_N   = 16;

    localparam int K_REG  = 0;
    localparam int K_MULT = 1;
    localparam int K_DIV  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic [11:0] fll_mult_o;
    logic [3:0]  ref_div_log2_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        logic [15:0] mask;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  item_ev;

    always #2 clk = ~clk;

    clkgen_ctrl_regs #(
        .OSC_START_CYC(OSC_CYC), .REF_SW_CYC(REF_CYC),
        .CLK_SW_CYC(CLK_CYC), .LOCK_CYC(LOCK_N)
    ) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fll_mult_o(fll_mult_o), .ref_div_log2_o(ref_div_log2_o)
    );

    // Monitor: pops each expected item and compares against the live outputs.
    initial begin
        forever begin
            item_t       it;
            logic [15:0] act;
            @(item_ev);
            #0.1;
            it = sb_q.pop_front();
            case (it.kind)
                K_MULT:  act = {4'd0, fll_mult_o};
                K_DIV:   act = {12'd0, ref_div_log2_o};
                default: act = {8'd0, bus_rdata};
            endcase
            n_checks++;
            if ((act & it.mask) != (it.exp & it.mask)) begin
                n_fail++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag,
                         act & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic expect_val(input int kind, input logic [1:0] addr,
                              input logic [15:0] exp, input logic [15:0] mask,
                              input string tag);
        item_t it;
        if (kind == K_REG) bus_addr = addr;
        it.kind = kind; it.exp = exp; it.mask = mask; it.tag = tag;
        sb_q.push_back(it);
        -> item_ev;
        #0.2;
    endtask

    task automatic reg_is(input logic [1:0] addr, input logic [7:0] exp, input string tag);
        expect_val(K_REG, addr, {8'd0, exp}, 16'h00FF, tag);
    endtask

    task automatic stat_bits(input logic [7:0] exp, input logic [7:0] mask, input string tag);
        expect_val(K_REG, 2'd3, {8'd0, exp}, {8'd0, mask}, tag);
    endtask

    task automatic wr(input logic [1:0] addr, input logic [7:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        reg_is(2'd0, 8'h02, "R1 clock reg reset");
        reg_is(2'd1, 8'h00, "R1 osc reg reset");
        reg_is(2'd2, 8'h00, "R1 range reg reset");
        reg_is(2'd3, 8'h10, "R1 status reset");
        expect_val(K_MULT, 2'd0, 16'd512, 16'hFFFF, "R7 reset multiplier");
        idle(1);
        expect_val(K_DIV, 2'd0, 16'd0, 16'hFFFF, "R8 reset divide");

        idle(LOCK_N + 2);
        stat_bits(8'h40, 8'h40, "R11 lock acquired with internal reference");

        // R9 write to status changes nothing
        wr(2'd3, 8'h00);
        reg_is(2'd3, 8'h50, "R9 status after ignored write");
        reg_is(2'd0, 8'h02, "R9 clock reg after status write");
        reg_is(2'd2, 8'h00, "R9 range reg after status write");

        // R3 oscillator start-up
        wr(2'd1, 8'h36);
        reg_is(2'd1, 8'h36, "R2 osc readback");
        idle(OSC_CYC - 1);
        stat_bits(8'h00, 8'h02, "R3 osc not ready one cycle early");
        idle(1);
        stat_bits(8'h02, 8'h02, "R3 osc ready on time");

        // R8 divider in high range
        wr(2'd0, 8'h1A);
        reg_is(2'd0, 8'h1A, "R2 clock readback");
        expect_val(K_DIV, 2'd0, 16'd8, 16'hFFFF, "R8 code 011 high range");

        // R4 switch to external reference, R5 lock loss on reference change
        wr(2'd0, 8'h18);
        idle(REF_CYC);
        stat_bits(8'h10, 8'h10, "R4 reference still internal");
        idle(1);
        stat_bits(8'h40, 8'h50, "R4 external reference in use, lock held");
        idle(1);
        stat_bits(8'h00, 8'h40, "R5 lock lost after reference switch");
        idle(LOCK_N - 1);
        stat_bits(8'h00, 8'h40, "R5 lock not yet back");
        idle(1);
        stat_bits(8'h40, 8'h40, "R5 lock reacquired");

        // R5/R7 range change
        wr(2'd2, 8'h01);
        expect_val(K_MULT, 2'd0, 16'd1024, 16'hFFFF, "R7 range 01");
        stat_bits(8'h40, 8'h40, "R5 lock held first cycle after write");
        idle(1);
        stat_bits(8'h00, 8'h40, "R5 lock dropped by range change");
        idle(LOCK_N - 1);
        stat_bits(8'h00, 8'h40, "R5 lock still acquiring");
        idle(1);
        stat_bits(8'h40, 8'h40, "R5 lock back after range change");
        wr(2'd2, 8'h01);
        idle(2);
        stat_bits(8'h40, 8'h40, "R5 same range code keeps lock");

        // R6 source switch to external
        wr(2'd0, 8'h98);
        idle(CLK_CYC);
        stat_bits(8'h00, 8'h0C, "R6 source not yet switched");
        idle(1);
        stat_bits(8'h48, 8'h4C, "R6 external source active, R11 lock kept");

        // R6 reserved code never adopted
        wr(2'd0, 8'hD8);
        reg_is(2'd0, 8'hD8, "R2 reserved source stored");
        idle(CLK_CYC + 4);
        stat_bits(8'h08, 8'h0C, "R6 reserved code ignored");

        wr(2'd0, 8'h58);
        idle(CLK_CYC);
        stat_bits(8'h08, 8'h0C, "R6 internal source pending");
        idle(1);
        stat_bits(8'h44, 8'h4C, "R6 internal source active, R11 lock kept");

        // R3 disable oscillator, R4 fall back to internal reference
        wr(2'd1, 8'h30);
        stat_bits(8'h02, 8'h02, "R3 ready holds until next edge");
        idle(1);
        stat_bits(8'h00, 8'h02, "R3 ready cleared");
        idle(REF_CYC);
        stat_bits(8'h00, 8'h10, "R4 external reference still in use");
        idle(1);
        stat_bits(8'h10, 8'h10, "R4 back on internal reference");

        // R2 masks, R7 and R8 remaining codes, R10 isolation
        wr(2'd2, 8'hFF);
        reg_is(2'd2, 8'h03, "R2 range mask");
        expect_val(K_MULT, 2'd0, 16'd2048, 16'hFFFF, "R7 range 11");
        reg_is(2'd0, 8'h58, "R10 clock reg after range write");
        wr(2'd2, 8'h02);
        expect_val(K_MULT, 2'd0, 16'd1536, 16'hFFFF, "R7 range 10");
        wr(2'd1, 8'hFF);
        reg_is(2'd1, 8'h36, "R2 osc mask");
        expect_val(K_DIV, 2'd0, 16'd8, 16'hFFFF, "R8 high range again");
        wr(2'd1, 8'h00);
        expect_val(K_DIV, 2'd0, 16'd3, 16'hFFFF, "R8 low range");
        reg_is(2'd2, 8'h02, "R10 range reg after osc write");
        wr(2'd0, 8'hFF);
        reg_is(2'd0, 8'hFA, "R2 clock mask");
        reg_is(2'd1, 8'h00, "R10 osc reg after clock write");

        idle(2);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule